// File: doc/BRIEF.md
# Paired Floating-Point Register File

This block is the register storage of a floating-point coprocessor. It keeps thirty-two 32-bit general registers in a single physical store. Software can use that store as 32 single-width registers. It can also use it as 16 double-width registers, where each one joins an even-numbered word with the odd word directly above it. A double-precision value always occupies both words of its pair.

The file has two combinational read ports and one write port. Each of the three ports carries its own mode bit, which picks a 32-bit single access or a 64-bit paired access.

A separate control space holds two registers:

- a control/status register, which holds the rounding mode, exception flags, exception enables and a flush mode bit;
- a read-only revision register.

This control space is reached only through the dedicated move port, never through the general read and write ports. The arithmetic units drive the control/status register through that move port and read the rounding mode from a dedicated output. The block itself does no arithmetic and raises no exceptions.

Top module: `fp_regbank`

## Requirements
- R1: A single-mode write (`wr_dbl`=0) stores `wr_data[31:0]` in word `wr_idx` at the next rising clock edge. A single-mode read returns that word on bits [31:0] of the read port and zero on bits [63:32].
- R2: A paired read (`rd*_dbl`=1) with an even index n returns word n on bits [31:0] and word n+1 on bits [63:32].
- R3: A paired write with an even index n updates word n with `wr_data[31:0]` and word n+1 with `wr_data[63:32]` on the same clock edge. Single-mode reads of n and n+1 then see the two halves.
- R4: A paired access with an odd index is illegal and drives `bad_pair` high in the same cycle. A paired write with an odd index changes no word. A paired read with an odd index returns all zeros.
- R5: Reads are read-before-write. A read in the same cycle as a write to the same word returns the old contents, and the new value appears after the clock edge.
- R6: The two read ports are independent. Each uses its own index and mode in the same cycle.
- R7: While reset is asserted, and after it is released, the control/status register reads 0 and `round_mode` is 0. The general registers are not reset.
- R8: A move write (`ctl_wr`=1, `ctl_sel`=0) loads the control/status register at the next edge with only bits [12:0] of `ctl_wdata`. The bit layout is: [1:0] rounding mode, [6:2] exception flags, [11:7] exception enables, [12] flush mode. Bits [31:13] always read 0.
- R9: `round_mode` always equals control/status bits [1:0]. The encoding is 0 = nearest, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. It changes only on a move write to the control/status register.
- R10: With `ctl_sel`=1, `ctl_rdata` returns the parameter `REV_ID`. Move writes with `ctl_sel`=1 are ignored and do not disturb the control/status register.
- R11: The general and control spaces are disjoint. General-port writes never change the control/status register, and move writes never change a general register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| wr_en | input | 1 | General write strobe |
| wr_dbl | input | 1 | Write mode: 0 = 32-bit word, 1 = 64-bit pair |
| wr_idx | input | 5 | Write register number (must be even for a pair) |
| wr_data | input | 64 | Write data; bits [63:32] are used only for a pair |
| rda_idx | input | 5 | Read port A register number |
| rda_dbl | input | 1 | Read port A mode |
| rda_data | output | 64 | Read port A data |
| rdb_idx | input | 5 | Read port B register number |
| rdb_dbl | input | 1 | Read port B mode |
| rdb_data | output | 64 | Read port B data |
| bad_pair | output | 1 | A paired access named an odd register on some port |
| ctl_wr | input | 1 | Move-to-control write strobe |
| ctl_sel | input | 1 | Control register select: 0 = control/status, 1 = revision |
| ctl_wdata | input | 32 | Move-to-control data |
| ctl_rdata | output | 32 | Move-from-control data for the selected register |
| round_mode | output | 2 | Current rounding-mode field |

## Verification
The bench builds the block with the default 32-word, 32-bit geometry, so every pair boundary it checks is a real one. It overrides `REV_ID` with a value different from the default. A correct revision read therefore shows that the value comes from the parameter and not from a constant. With this setting, odd-index pair accesses, writes and reads to the same word in one cycle, and every rounding code are all reachable through the ports.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_WORDS = 32;
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);
  localparam int unsigned PAIR_W    = 2 * WORD_W;
  localparam int unsigned NUM_RD    = 2;

  // control/status layout
  localparam int unsigned RND_LSB   = 0;
  localparam int unsigned FLG_LSB   = 2;
  localparam int unsigned ENA_LSB   = 7;
  localparam int unsigned FLUSH_BIT = 12;
  localparam int unsigned CSR_USED  = FLUSH_BIT + 1;
  localparam logic [WORD_W-1:0] CSR_MASK = WORD_W'((64'd1 << CSR_USED) - 64'd1);

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_PINF = 2'd2,
    RND_MINF = 2'd3
  } rnd_mode_e;

  typedef enum logic {
    CTL_STATUS = 1'b0,
    CTL_REV    = 1'b1
  } ctl_sel_e;
endpackage

// File: rtl/fpr_store.sv
module fpr_store
  import fpr_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned N  = NUM_WORDS,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               dbl,
  input  logic [IW-1:0]      idx,
  input  logic [2*W-1:0]     wdata,
  output logic [N-1:0][W-1:0] words,
  output logic               wr_bad
);
  logic [N-1:0]       wen;
  logic [W-1:0]       mem [N];
  logic [W-1:0]       lo_half;
  logic [W-1:0]       hi_half;
  logic [IW-1:0]      odd_idx;

  assign lo_half = wdata[W-1:0];
  assign hi_half = wdata[2*W-1:W];
  assign odd_idx = idx | IW'(1);

  // next-state: per-word write enables
  always_comb begin
    wen    = '0;
    wr_bad = we && dbl && idx[0];
    if (we) begin
      if (!dbl) begin
        wen[idx] = 1'b1;
      end else if (!idx[0]) begin
        wen[idx]     = 1'b1;
        wen[odd_idx] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_word
    logic [W-1:0] word_d;
    if (i % 2 == 1) begin : g_odd
      assign word_d = dbl ? hi_half : lo_half;
    end else begin : g_even
      assign word_d = lo_half;
    end
    always_ff @(posedge clk) begin
      if (wen[i]) mem[i] <= word_d;
    end
    assign words[i] = mem[i];
  end

  // R4
  odd_pair_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && dbl && idx[0]) |-> (wen == '0));
  // R3
  pair_wr_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && dbl && !idx[0]) |-> ($countones(wen) == 2));
  // R1
  single_wr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !dbl) |-> ($countones(wen) == 1));
endmodule

// File: rtl/fpr_rdport.sv
module fpr_rdport
  import fpr_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned N  = NUM_WORDS,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0][W-1:0] words,
  input  logic                dbl,
  input  logic [IW-1:0]       idx,
  output logic [2*W-1:0]      rdata,
  output logic                bad
);
  logic [IW-1:0] odd_idx;
  assign odd_idx = idx | IW'(1);

  always_comb begin
    bad = dbl && idx[0];
    if (!dbl) begin
      rdata = {{W{1'b0}}, words[idx]};
    end else if (idx[0]) begin
      rdata = '0;
    end else begin
      rdata = {words[odd_idx], words[idx]};
    end
  end

  // R1
  single_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl |-> (rdata[2*W-1:W] == '0));
  // R4
  odd_pair_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl && idx[0]) |-> (rdata == '0 && bad));
endmodule

// File: rtl/fpr_ctl.sv
module fpr_ctl
  import fpr_pkg::*;
#(
  parameter logic [WORD_W-1:0] REV_ID = 32'h0000_0301
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [1:0]        round_mode
);
  logic [WORD_W-1:0] csr_q;
  logic [WORD_W-1:0] csr_d;
  logic              csr_en;

  always_comb begin
    csr_en = wr && (ctl_sel_e'(sel) == CTL_STATUS);
    csr_d  = wdata & CSR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_q <= '0;
    else if (csr_en) csr_q <= csr_d;
  end

  assign rdata      = (ctl_sel_e'(sel) == CTL_REV) ? REV_ID : csr_q;
  assign round_mode = csr_q[RND_LSB +: 2];

  // R10
  rev_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel) |=> $stable(csr_q));
  // R9
  rnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(round_mode));
  // R8
  csr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel) |-> (rdata[WORD_W-1:CSR_USED] == '0));
endmodule

// File: rtl/fp_regbank.sv
module fp_regbank
  import fpr_pkg::*;
#(
  parameter logic [31:0] REV_ID = 32'h0000_0301
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_dbl,
  input  logic [4:0]  wr_idx,
  input  logic [63:0] wr_data,
  input  logic [4:0]  rda_idx,
  input  logic        rda_dbl,
  output logic [63:0] rda_data,
  input  logic [4:0]  rdb_idx,
  input  logic        rdb_dbl,
  output logic [63:0] rdb_data,
  output logic        bad_pair,
  input  logic        ctl_wr,
  input  logic        ctl_sel,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  output logic [1:0]  round_mode
);
  logic [1:0]                         rst_sync_q;
  logic                               rst_int_n;
  logic [NUM_WORDS-1:0][WORD_W-1:0]   words;
  logic                               wr_bad;
  logic [IDX_W-1:0]                   rd_idx  [NUM_RD];
  logic                               rd_dbl  [NUM_RD];
  logic [PAIR_W-1:0]                  rd_data [NUM_RD];
  logic [NUM_RD-1:0]                  rd_bad;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fpr_store #(.W(WORD_W), .N(NUM_WORDS), .IW(IDX_W)) u_store (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (wr_en),
    .dbl   (wr_dbl),
    .idx   (wr_idx),
    .wdata (wr_data),
    .words (words),
    .wr_bad(wr_bad)
  );

  assign rd_idx[0] = rda_idx;
  assign rd_dbl[0] = rda_dbl;
  assign rd_idx[1] = rdb_idx;
  assign rd_dbl[1] = rdb_dbl;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    fpr_rdport #(.W(WORD_W), .N(NUM_WORDS), .IW(IDX_W)) u_rd (
      .clk   (clk),
      .rst_n (rst_int_n),
      .words (words),
      .dbl   (rd_dbl[p]),
      .idx   (rd_idx[p]),
      .rdata (rd_data[p]),
      .bad   (rd_bad[p])
    );
  end

  assign rda_data = rd_data[0];
  assign rdb_data = rd_data[1];
  assign bad_pair = wr_bad | (|rd_bad);

  fpr_ctl #(.REV_ID(REV_ID)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr        (ctl_wr),
    .sel       (ctl_sel),
    .wdata     (ctl_wdata),
    .rdata     (ctl_rdata),
    .round_mode(round_mode)
  );

  // R11
  gen_wr_no_csr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !ctl_wr) |=> $stable(round_mode));
endmodule

// File: tb/sim_fp_regbank.sv
module sim_fp_regbank;
  localparam logic [31:0] TB_REV = 32'h0000_0A31;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_dbl;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  logic [4:0]  rda_idx, rdb_idx;
  logic        rda_dbl, rdb_dbl;
  logic [63:0] rda_data, rdb_data;
  logic        bad_pair;
  logic        ctl_wr, ctl_sel;
  logic [31:0] ctl_wdata, ctl_rdata;
  logic [1:0]  round_mode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          src;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  event smp;

  always #5 clk = ~clk;

  fp_regbank #(.REV_ID(TB_REV)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_data(wr_data),
    .rda_idx(rda_idx), .rda_dbl(rda_dbl), .rda_data(rda_data),
    .rdb_idx(rdb_idx), .rdb_dbl(rdb_dbl), .rdb_data(rdb_data),
    .bad_pair(bad_pair),
    .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .round_mode(round_mode)
  );

  function automatic logic [63:0] observe(int src);
    case (src)
      0: return rda_data;
      1: return rdb_data;
      2: return {32'b0, ctl_rdata};
      3: return {62'b0, round_mode};
      default: return {63'b0, bad_pair};
    endcase
  endfunction

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(smp);
      while (q.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = q.pop_front();
        act = observe(it.src);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s src=%0d actual=%h expected=%h", it.tag, it.src, act, it.exp);
        end
      end
    end
  end

  task automatic push(int src, logic [63:0] e, string tag);
    item_t it;
    it.src = src; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic sample();
    #1;
    ->smp;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; ctl_wr = 0;
  endtask

  task automatic gwrite(logic dbl, logic [4:0] idx, logic [63:0] d);
    @(negedge clk);
    ctl_wr = 0;
    wr_en = 1; wr_dbl = dbl; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cwrite(logic sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 0;
    ctl_wr = 1; ctl_sel = sel; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic rd(logic [4:0] ai, logic ad, logic [4:0] bi, logic bd);
    rda_idx = ai; rda_dbl = ad; rdb_idx = bi; rdb_dbl = bd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_dbl = 0; wr_idx = 0; wr_data = 0;
    ctl_wr = 0; ctl_sel = 0; ctl_wdata = 0;
    rd(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    // R7 during reset
    push(2, 64'h0, "R7 csr in reset");
    push(3, 64'h0, "R7 round in reset");
    sample();
    rst_n = 1;
    repeat (3) @(negedge clk);
    push(2, 64'h0, "R7 csr after reset");
    push(3, 64'h0, "R7 round after reset");
    sample();

    // R1 single writes
    gwrite(0, 5'd4, 64'hFFFF_FFFF_1111_AAAA);
    gwrite(0, 5'd5, 64'h0000_0000_2222_BBBB);
    rd(4, 0, 5, 0);
    push(0, 64'h0000_0000_1111_AAAA, "R1 single read r4");
    push(1, 64'h0000_0000_2222_BBBB, "R1 single read r5");
    push(4, 64'h0, "R1 no bad flag");
    sample();

    // R2 pair read
    rd(4, 1, 4, 0);
    push(0, 64'h2222_BBBB_1111_AAAA, "R2 pair read 4");
    push(1, 64'h0000_0000_1111_AAAA, "R6 port b single");
    sample();

    // R3 pair write
    gwrite(1, 5'd8, 64'hDDDD_0009_CCCC_0008);
    rd(8, 0, 9, 0);
    push(0, 64'h0000_0000_CCCC_0008, "R3 low half to r8");
    push(1, 64'h0000_0000_DDDD_0009, "R3 high half to r9");
    sample();

    // R5 read-before-write
    @(negedge clk);
    wr_en = 1; wr_dbl = 0; wr_idx = 5'd4; wr_data = 64'h0000_0000_EEEE_4444;
    rd(4, 0, 4, 1);
    push(0, 64'h0000_0000_1111_AAAA, "R5 old value same cycle");
    push(1, 64'h2222_BBBB_1111_AAAA, "R5 old pair same cycle");
    sample();
    @(negedge clk);
    wr_en = 0;
    push(0, 64'h0000_0000_EEEE_4444, "R5 new value after edge");
    sample();

    // R4 odd pair write suppressed
    @(negedge clk);
    wr_en = 1; wr_dbl = 1; wr_idx = 5'd9; wr_data = 64'h5555_5555_6666_6666;
    push(4, 64'h1, "R4 bad flag on odd pair write");
    sample();
    @(negedge clk);
    wr_en = 0;
    rd(8, 0, 9, 0);
    push(0, 64'h0000_0000_CCCC_0008, "R4 r8 unchanged");
    push(1, 64'h0000_0000_DDDD_0009, "R4 r9 unchanged");
    push(4, 64'h0, "R4 flag clear");
    sample();

    // R4 odd pair read
    rd(9, 1, 8, 1);
    push(0, 64'h0, "R4 odd pair read zero");
    push(1, 64'hDDDD_0009_CCCC_0008, "R6 port b pair");
    push(4, 64'h1, "R4 bad flag on odd read");
    sample();
    rd(0, 0, 0, 0);

    // R8 csr mask
    cwrite(0, 32'hFFFF_FFFF);
    ctl_sel = 0;
    push(2, 64'h0000_1FFF, "R8 csr masked");
    push(3, 64'h3, "R9 round from all-ones");
    sample();
    cwrite(0, 32'h0000_1555);
    ctl_sel = 0;
    push(2, 64'h0000_1555, "R8 csr pattern");
    sample();

    // R9 every rounding code
    for (int k = 0; k < 4; k++) begin
      cwrite(0, 32'h0000_0F80 | 32'(k));
      push(3, 64'(k), "R9 rounding code");
      sample();
    end

    // R10 revision
    cwrite(1, 32'hDEAD_BEEF);
    ctl_sel = 1;
    push(2, {32'b0, TB_REV}, "R10 revision value");
    push(3, 64'h3, "R10 round undisturbed");
    sample();
    ctl_sel = 0;
    push(2, 64'h0000_0F83, "R10 csr undisturbed");
    sample();

    // R11 disjoint spaces
    gwrite(1, 5'd0, 64'h0123_4567_89AB_CDEF);
    ctl_sel = 0;
    push(2, 64'h0000_0F83, "R11 csr after general write");
    sample();
    cwrite(0, 32'h0000_0000);
    rd(4, 0, 0, 1);
    push(0, 64'h0000_0000_EEEE_4444, "R11 r4 after move write");
    push(1, 64'h0123_4567_89AB_CDEF, "R11 pair0 after move write");
    push(3, 64'h0, "R9 round back to nearest");
    sample();

    idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule